// File: doc/BRIEF.md
# Host-to-DSP Mailbox Bridge

The bridge sits between an external host processor bus and an embedded DSP core. The host sees a small peripheral of sixteen word locations. The DSP sees four word locations in its data space. Words travel in two directions, each through its own two-stage buffer. A "downlink" carries words from the host to the DSP. An "uplink" carries words from the DSP to the host. Because each path has two stages, one side can deposit a new word while the other side still holds the previous one. Handshake flags can be polled on both sides, and the same flags drive an interrupt line toward each side. When the host enables a channel, the flags also drive a per-channel request line that an external DMA controller can use. A dedicated host acknowledge input reaches the data location directly, whatever the host address lines carry.

The host can also ask the DSP to run one of 256 exception routines. It writes a vector number, and the bridge holds a pending request together with that vector until the DSP acknowledges it. There are two local reset sources besides the system reset. A DSP-owned hold bit keeps every status flag cleared for as long as it is set. A host-owned self-clearing initialise bit clears the status of a chosen channel or of both channels.

The DSP clock can be stopped, which is modelled by a run input. While it is low, the host can still read and write its locations. Every transfer between buffer stages and every DSP access waits and then finishes once the run input returns high.

Top module: `hif_bridge`

## Requirements
- R1: After synchronous reset: the host status reads 0x1 (downlink room, bit0 = 1; uplink data available, bit1 = 0; command pending, bit2 = 0; hold, bit3 = 0). The DSP status reads 0x2 (downlink data available, bit0 = 0; uplink room, bit1 = 1; command pending, bit2 = 0). All request outputs are low.
- R2: A host write to host location 3 enters the downlink first stage. The word moves to the second stage one clock later if that stage is empty. A DSP read of DSP location 2 returns the second-stage word. A host write while the first stage is full is dropped.
- R3: A DSP write to DSP location 2 enters the uplink first stage and moves to the host-facing stage one clock later if that stage is empty. A host read of location 3 returns that word. A DSP write while the first stage is full is dropped.
- R4: A read of a full second stage, made while the first stage is also full, takes the queued word in the same clock. The read side therefore stays full with the next word, and word order is preserved.
- R5: Host control location 0 has bit0 = downlink enable and bit1 = uplink enable. host_dreq_dn equals downlink enable AND downlink room. host_dreq_up equals uplink enable AND uplink data available. host_irq is the OR of the two.
- R6: DSP control location 0 has bit1 = downlink interrupt enable and bit2 = uplink interrupt enable. dsp_irq is (bit1 AND downlink data available) OR (bit2 AND uplink room).
- R7: While host_ack is high, the access goes to the data location (host location 3) whatever host_addr and host_cs are.
- R8: A host write to location 2 with no command pending loads the vector (bits 7:0) and raises dsp_exc_req on the next clock, with dsp_exc_vec showing the vector. Host writes while a command is pending are ignored. The request clears on the clock after dsp_exc_ack is sampled with dsp_run high. Host location 2 reads {pending at bit8, vector at bits 7:0}.
- R9: DSP control bit0 (hold) clears all buffer flags and the pending command from the clock after it is set. It keeps them cleared while set and does not clear itself. Control bits are kept. Host status bit3 reflects the hold bit.
- R10: A host control write with bit4 set clears the downlink flags if the written bit0 is 1, and the uplink flags if the written bit1 is 1. Bit4 always reads back as 0.
- R11: While dsp_run is low, no word moves between stages and DSP accesses and acknowledges have no effect. Host accesses still work, and pending moves complete after dsp_run rises.
- R12: Host locations 4 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host select for an addressed access |
| host_ack | input | 1 | DMA acknowledge, forces data location |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 4 | Host word location |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_irq | output | 1 | Host interrupt request |
| host_dreq_dn | output | 1 | DMA request, downlink has room |
| host_dreq_up | output | 1 | DMA request, uplink has data |
| dsp_run | input | 1 | DSP clock running |
| dsp_cs | input | 1 | DSP select |
| dsp_we | input | 1 | DSP write (1) or read (0) |
| dsp_addr | input | 2 | DSP word location |
| dsp_wdata | input | 32 | DSP write data |
| dsp_rdata | output | 32 | DSP read data |
| dsp_irq | output | 1 | DSP interrupt request |
| dsp_exc_ack | input | 1 | DSP acknowledges the host command |
| dsp_exc_req | output | 1 | Host command exception pending |
| dsp_exc_vec | output | 8 | Host command vector |

## Verification
The hardest state to reach is a stage move that is held back by a stopped DSP clock. The same is true of a same-clock read-and-move with both stages full. In that case a careless host write or DSP read drains the buffer before the case arises. The stimulus fills a path with idle clocks between writes so that each word settles into place. It then drops dsp_run, adds a host word and tries a DSP read. It checks that the DSP side stays unchanged until run returns. The hold and initialise tests first load both paths and a pending command, so that clearing one channel while the other is kept can be seen.

// File: rtl/hif_pkg.sv
// Shared constants of the host/DSP mailbox bridge: register locations on
// both sides and control bit positions.
package hif_pkg;
    // host-side word locations
    localparam int H_CTRL = 0;
    localparam int H_STAT = 1;
    localparam int H_CMD  = 2;
    localparam int H_DATA = 3;
    // DSP-side word locations
    localparam int D_CTRL = 0;
    localparam int D_STAT = 1;
    localparam int D_DATA = 2;
    localparam int D_VEC  = 3;
    // host control bits
    localparam int CB_EN_DN = 0;
    localparam int CB_EN_UP = 1;
    localparam int CB_INIT  = 4;
    // DSP control bits
    localparam int DB_HOLD   = 0;
    localparam int DB_IRQ_DN = 1;
    localparam int DB_IRQ_UP = 2;
endpackage

// File: rtl/hif_mailbox.sv
// Two-stage one-way mailbox. The writer fills stage 0 and the reader drains
// stage 1. A word moves from stage 0 to stage 1 when xfer_en is high and
// stage 1 is empty or is being read in the same clock.
// Assumes: writes to a full stage 0 and reads of an empty stage 1 are
// dropped; clr clears the flags only and has priority.
module hif_mailbox #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         xfer_en,
    output logic [W-1:0] rd_data,
    output logic         wr_room,
    output logic         rd_avail
);
    logic         s0_full, s1_full;
    logic [W-1:0] s0_q, s1_q;
    logic         rd_ok, wr_ok, move;

    // accepted accesses and the stage-to-stage move
    always_comb begin
        rd_ok = rd_en & s1_full;
        wr_ok = wr_en & ~s0_full;
        move  = s0_full & (~s1_full | rd_ok) & xfer_en;
    end

    // stage 0: writer side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_full <= 1'b0;
            s0_q    <= '0;
        end else if (clr) begin
            s0_full <= 1'b0;
        end else if (wr_ok) begin
            s0_full <= 1'b1;
            s0_q    <= wr_data;
        end else if (move) begin
            s0_full <= 1'b0;
        end
    end

    // stage 1: reader side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_full <= 1'b0;
            s1_q    <= '0;
        end else if (clr) begin
            s1_full <= 1'b0;
        end else if (move) begin
            s1_full <= 1'b1;
            s1_q    <= s0_q;
        end else if (rd_ok) begin
            s1_full <= 1'b0;
        end
    end

    assign rd_data  = s1_q;
    assign wr_room  = ~s0_full;
    assign rd_avail = s1_full;
endmodule

// File: rtl/hif_cmd.sv
// Host command slot: holds an exception vector and a pending flag until the
// DSP acknowledges. Assumes wr_en is ignored while pending; clr drops the
// pending flag but keeps the vector.
module hif_cmd #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             ack,
    output logic             pending,
    output logic [VEC_W-1:0] vec
);
    // pending flag and vector latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            vec     <= '0;
        end else if (clr) begin
            pending <= 1'b0;
        end else if (wr_en && !pending) begin
            pending <= 1'b1;
            vec     <= wr_vec;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/hif_bridge.sv
// Host/DSP mailbox bridge top. It decodes the host locations (with a DMA
// acknowledge that forces the data location) and the DSP locations. It holds
// both sides' control bits, the two mailboxes and the command slot.
// Assumes one clock; dsp_run low stands for a stopped DSP clock.
module hif_bridge #(
    parameter int DATA_W  = 32,
    parameter int HADDR_W = 4,
    parameter int DADDR_W = 2,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_ack,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_irq,
    output logic               host_dreq_dn,
    output logic               host_dreq_up,
    input  logic               dsp_run,
    input  logic               dsp_cs,
    input  logic               dsp_we,
    input  logic [DADDR_W-1:0] dsp_addr,
    input  logic [DATA_W-1:0]  dsp_wdata,
    output logic [DATA_W-1:0]  dsp_rdata,
    output logic               dsp_irq,
    input  logic               dsp_exc_ack,
    output logic               dsp_exc_req,
    output logic [VEC_W-1:0]   dsp_exc_vec
);
    import hif_pkg::*;

    localparam logic [HADDR_W-1:0] HA_CTRL = HADDR_W'(H_CTRL);
    localparam logic [HADDR_W-1:0] HA_STAT = HADDR_W'(H_STAT);
    localparam logic [HADDR_W-1:0] HA_CMD  = HADDR_W'(H_CMD);
    localparam logic [HADDR_W-1:0] HA_DATA = HADDR_W'(H_DATA);
    localparam logic [DADDR_W-1:0] DA_CTRL = DADDR_W'(D_CTRL);
    localparam logic [DADDR_W-1:0] DA_STAT = DADDR_W'(D_STAT);
    localparam logic [DADDR_W-1:0] DA_DATA = DADDR_W'(D_DATA);
    localparam logic [DADDR_W-1:0] DA_VEC  = DADDR_W'(D_VEC);

    logic [HADDR_W-1:0] h_idx;
    logic               h_wr, h_rd, d_wr, d_rd;
    logic               en_dn_q, en_up_q;
    logic               hres_q, dirq_dn_q, dirq_up_q;
    logic               init_pulse, clr_dn, clr_up;
    logic [DATA_W-1:0]  dn_rdata, up_rdata;
    logic               dn_room, dn_avail, up_room, up_avail;
    logic               cmd_pend;
    logic [VEC_W-1:0]   cmd_vec;

    // access decode; the DMA acknowledge overrides the address lines
    always_comb begin
        h_idx = host_ack ? HA_DATA : host_addr;
        h_wr  = (host_cs | host_ack) & host_we;
        h_rd  = (host_cs | host_ack) & ~host_we;
        d_wr  = dsp_cs & dsp_run & dsp_we;
        d_rd  = dsp_cs & dsp_run & ~dsp_we;
    end

    // local resets: held hold bit, or one-shot initialise per channel
    always_comb begin
        init_pulse = h_wr && (h_idx == HA_CTRL) && host_wdata[CB_INIT];
        clr_dn = hres_q | (init_pulse & host_wdata[CB_EN_DN]);
        clr_up = hres_q | (init_pulse & host_wdata[CB_EN_UP]);
    end

    // host control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_dn_q <= 1'b0;
            en_up_q <= 1'b0;
        end else if (h_wr && h_idx == HA_CTRL) begin
            en_dn_q <= host_wdata[CB_EN_DN];
            en_up_q <= host_wdata[CB_EN_UP];
        end
    end

    // DSP control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hres_q    <= 1'b0;
            dirq_dn_q <= 1'b0;
            dirq_up_q <= 1'b0;
        end else if (d_wr && dsp_addr == DA_CTRL) begin
            hres_q    <= dsp_wdata[DB_HOLD];
            dirq_dn_q <= dsp_wdata[DB_IRQ_DN];
            dirq_up_q <= dsp_wdata[DB_IRQ_UP];
        end
    end

    hif_mailbox #(.W(DATA_W)) u_dn (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_dn),
        .wr_en   (h_wr && h_idx == HA_DATA),
        .wr_data (host_wdata),
        .rd_en   (d_rd && dsp_addr == DA_DATA),
        .xfer_en (dsp_run),
        .rd_data (dn_rdata),
        .wr_room (dn_room),
        .rd_avail(dn_avail)
    );

    hif_mailbox #(.W(DATA_W)) u_up (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_up),
        .wr_en   (d_wr && dsp_addr == DA_DATA),
        .wr_data (dsp_wdata),
        .rd_en   (h_rd && h_idx == HA_DATA),
        .xfer_en (dsp_run),
        .rd_data (up_rdata),
        .wr_room (up_room),
        .rd_avail(up_avail)
    );

    hif_cmd #(.VEC_W(VEC_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hres_q),
        .wr_en  (h_wr && h_idx == HA_CMD),
        .wr_vec (host_wdata[VEC_W-1:0]),
        .ack    (dsp_exc_ack & dsp_run),
        .pending(cmd_pend),
        .vec    (cmd_vec)
    );

    // host read multiplexer
    always_comb begin
        case (h_idx)
            HA_CTRL: host_rdata = DATA_W'({en_up_q, en_dn_q});
            HA_STAT: host_rdata = DATA_W'({hres_q, cmd_pend, up_avail, dn_room});
            HA_CMD:  host_rdata = DATA_W'({cmd_pend, cmd_vec});
            HA_DATA: host_rdata = up_rdata;
            default: host_rdata = '0;
        endcase
    end

    // DSP read multiplexer
    always_comb begin
        case (dsp_addr)
            DA_CTRL: dsp_rdata = DATA_W'({dirq_up_q, dirq_dn_q, hres_q});
            DA_STAT: dsp_rdata = DATA_W'({cmd_pend, up_room, dn_avail});
            DA_DATA: dsp_rdata = dn_rdata;
            DA_VEC:  dsp_rdata = DATA_W'(cmd_vec);
            default: dsp_rdata = '0;
        endcase
    end

    // request outputs
    always_comb begin
        host_dreq_dn = en_dn_q & dn_room;
        host_dreq_up = en_up_q & up_avail;
        host_irq     = host_dreq_dn | host_dreq_up;
        dsp_irq      = (dirq_dn_q & dn_avail) | (dirq_up_q & up_room);
        dsp_exc_req  = cmd_pend;
        dsp_exc_vec  = cmd_vec;
    end
endmodule

// File: rtl/hif_bridge_chk.sv
// Property checker for hif_bridge, attached by the bind below.
module hif_bridge_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsp_run,
    input logic             dsp_exc_ack,
    input logic             dsp_exc_req,
    input logic [VEC_W-1:0] dsp_exc_vec,
    input logic             hres_q,
    input logic             init_pulse,
    input logic             dn_room,
    input logic             dn_avail,
    input logic             up_room,
    input logic             up_avail,
    input logic             host_dreq_up
);
    // R8: a pending command and its vector stay until acknowledged
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dsp_exc_req && !(dsp_exc_ack && dsp_run) && !hres_q)
        |-> dsp_exc_req && $stable(dsp_exc_vec));

    // R11: with the DSP clock stopped the DSP-side flags do not move
    p_stall_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !dsp_run && !hres_q && !init_pulse)
        |-> $stable(dn_avail) && $stable(up_room));

    // R9: while held, every status flag stays cleared
    p_hold_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hres_q) |-> dn_room && !dn_avail && up_room && !up_avail && !dsp_exc_req);

    // R5: the uplink DMA request only with a word ready for the host
    p_dreq_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_dreq_up |-> up_avail);
endmodule

bind hif_bridge hif_bridge_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dsp_run     (dsp_run),
    .dsp_exc_ack (dsp_exc_ack),
    .dsp_exc_req (dsp_exc_req),
    .dsp_exc_vec (dsp_exc_vec),
    .hres_q      (hres_q),
    .init_pulse  (init_pulse),
    .dn_room     (dn_room),
    .dn_avail    (dn_avail),
    .up_room     (up_room),
    .up_avail    (up_avail),
    .host_dreq_up(host_dreq_up)
);

// File: tb/hif_bridge_test.sv
module hif_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 0, host_ack = 0, host_we = 0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq, host_dreq_dn, host_dreq_up;
    logic        dsp_run = 1'b1, dsp_cs = 0, dsp_we = 0, dsp_exc_ack = 0;
    logic [1:0]  dsp_addr = '0;
    logic [31:0] dsp_wdata = '0;
    logic [31:0] dsp_rdata;
    logic        dsp_irq, dsp_exc_req;
    logic [7:0]  dsp_exc_vec;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hif_bridge uut (.*);

    // behavioural reference state
    bit m_dnf, m_dnb, m_upb, m_upf, m_pend, m_en_dn, m_en_up, m_hold, m_idn, m_iup;
    logic [31:0] m_dnf_d, m_dnb_d, m_upb_d, m_upf_d;
    logic [7:0]  m_vec;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference update on each clock, from the requirement rules
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_dnf, m_dnb, m_upb, m_upf, m_pend, m_en_dn, m_en_up, m_hold, m_idn, m_iup} = '0;
            m_vec = 0;
        end else begin
            automatic bit acc = host_cs | host_ack;
            automatic int ha = host_ack ? 3 : int'(host_addr);
            automatic bit hw = acc && host_we;
            automatic bit hr = acc && !host_we;
            automatic bit dw = dsp_cs && dsp_run && dsp_we;
            automatic bit dr = dsp_cs && dsp_run && !dsp_we;
            automatic bit init = hw && ha == 0 && host_wdata[4];
            automatic bit cdn = m_hold || (init && host_wdata[0]);
            automatic bit cup = m_hold || (init && host_wdata[1]);
            automatic bit rdn = dr && dsp_addr == 2 && m_dnb;
            automatic bit mdn = m_dnf && (!m_dnb || rdn) && dsp_run;
            automatic bit rup = hr && ha == 3 && m_upf;
            automatic bit mup = m_upb && (!m_upf || rup) && dsp_run;
            automatic bit old_hold = m_hold;
            if (hw && ha == 0) begin m_en_dn = host_wdata[0]; m_en_up = host_wdata[1]; end
            if (dw && dsp_addr == 0) begin
                m_hold = dsp_wdata[0]; m_idn = dsp_wdata[1]; m_iup = dsp_wdata[2];
            end
            if (cdn) begin m_dnf = 0; m_dnb = 0; end
            else begin
                if (mdn) begin m_dnb = 1; m_dnb_d = m_dnf_d; end else if (rdn) m_dnb = 0;
                if (hw && ha == 3 && !m_dnf) begin m_dnf = 1; m_dnf_d = host_wdata; end
                else if (mdn) m_dnf = 0;
            end
            if (cup) begin m_upf = 0; m_upb = 0; end
            else begin
                if (mup) begin m_upf = 1; m_upf_d = m_upb_d; end else if (rup) m_upf = 0;
                if (dw && dsp_addr == 2 && !m_upb) begin m_upb = 1; m_upb_d = dsp_wdata; end
                else if (mup) m_upb = 0;
            end
            if (old_hold) m_pend = 0;
            else if (hw && ha == 2 && !m_pend) begin m_pend = 1; m_vec = host_wdata[7:0]; end
            else if (m_pend && dsp_exc_ack && dsp_run) m_pend = 0;
        end
    end

    // per-clock comparison of the state-driven outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 host_dreq_dn", 32'(host_dreq_dn), 32'(m_en_dn && !m_dnf));
            check("R5 host_dreq_up", 32'(host_dreq_up), 32'(m_en_up && m_upf));
            check("R5 host_irq", 32'(host_irq), 32'((m_en_dn && !m_dnf) || (m_en_up && m_upf)));
            check("R6 dsp_irq", 32'(dsp_irq), 32'((m_idn && m_dnb) || (m_iup && !m_upb)));
            check("R8 dsp_exc_req", 32'(dsp_exc_req), 32'(m_pend));
            check("R8 dsp_exc_vec", 32'(dsp_exc_vec), 32'(m_vec));
        end
    end

    // all tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic host_wr(input logic [3:0] a, input logic [31:0] d, input bit ack = 0);
        host_cs = !ack; host_ack = ack; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_ack = 0; host_we = 0;
    endtask
    task automatic host_rd(input logic [3:0] a, output logic [31:0] d, input bit ack = 0);
        host_cs = !ack; host_ack = ack; host_we = 0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 0; host_ack = 0;
    endtask
    task automatic host_peek(input logic [3:0] a, output logic [31:0] d);
        host_addr = a; #1 d = host_rdata;
    endtask
    task automatic dsp_wr(input logic [1:0] a, input logic [31:0] d);
        dsp_cs = 1; dsp_we = 1; dsp_addr = a; dsp_wdata = d;
        @(negedge clk);
        dsp_cs = 0; dsp_we = 0;
    endtask
    task automatic dsp_rd(input logic [1:0] a, output logic [31:0] d);
        dsp_cs = 1; dsp_we = 0; dsp_addr = a;
        #1 d = dsp_rdata;
        @(negedge clk);
        dsp_cs = 0;
    endtask
    task automatic dsp_peek(input logic [1:0] a, output logic [31:0] d);
        dsp_addr = a; #1 d = dsp_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        host_peek(1, v); check("R1 host status", v, 32'h1);
        dsp_peek(1, v);  check("R1 dsp status", v, 32'h2);
        check("R1 requests", 32'({host_irq, dsp_irq, dsp_exc_req}), 32'h0);

        // R2 downlink fill, overflow drop; R4 read-and-move
        host_wr(3, 32'hA1); idle(1);
        dsp_peek(1, v); check("R2 dn avail after move", v[0], 1);
        host_wr(3, 32'hA2);
        host_wr(3, 32'hA3);
        host_peek(1, v); check("R2 dn full no room", v[0], 0);
        dsp_rd(2, v); check("R2 first word", v, 32'hA1);
        dsp_peek(1, v); check("R4 still avail after read", v[0], 1);
        host_peek(1, v); check("R4 room after move", v[0], 1);
        dsp_rd(2, v); check("R4 order kept", v, 32'hA2);
        dsp_peek(1, v); check("R2 dropped word absent", v[0], 0);

        // R3 uplink
        dsp_wr(2, 32'hB1); idle(1);
        dsp_wr(2, 32'hB2); idle(1);
        host_peek(1, v); check("R3 up avail", v[1], 1);
        host_rd(3, v); check("R3 first word", v, 32'hB1);
        host_rd(3, v); check("R3 second word", v, 32'hB2);
        host_peek(1, v); check("R3 up empty", v[1], 0);

        // R5 DMA requests
        host_wr(0, 32'h3);
        check("R5 dreq_dn enabled", 32'(host_dreq_dn), 1);
        check("R5 dreq_up idle", 32'(host_dreq_up), 0);
        dsp_wr(2, 32'hC1); idle(1);
        check("R5 dreq_up raised", 32'(host_dreq_up), 1);

        // R7 acknowledge forces data location
        host_rd(4'h5, v, 1); check("R7 ack read", v, 32'hC1);
        host_wr(4'h0, 32'hF1, 1); idle(1);
        host_peek(0, v); check("R7 ctrl untouched", v, 32'h3);
        dsp_rd(2, v); check("R7 ack write landed", v, 32'hF1);

        // R6 DSP interrupt
        dsp_wr(0, 32'h2);
        check("R6 irq off when empty", 32'(dsp_irq), 0);
        host_wr(3, 32'hD1); idle(1);
        check("R6 irq on data", 32'(dsp_irq), 1);
        dsp_rd(2, v);
        dsp_wr(0, 32'h4);
        check("R6 irq on up room", 32'(dsp_irq), 1);
        dsp_wr(0, 32'h0);

        // R8 host command
        host_wr(2, 32'h5C);
        check("R8 req raised", 32'({dsp_exc_req, dsp_exc_vec}), 32'h15C);
        host_wr(2, 32'h11);
        check("R8 locked vector", 32'(dsp_exc_vec), 32'h5C);
        host_peek(2, v); check("R8 cmd readback", v, 32'h15C);
        dsp_exc_ack = 1; @(negedge clk); dsp_exc_ack = 0;
        check("R8 req cleared", 32'(dsp_exc_req), 0);

        // R11 stall
        dsp_run = 0;
        host_wr(3, 32'hE1); idle(2);
        dsp_peek(1, v); check("R11 no move while stopped", v[0], 0);
        dsp_wr(2, 32'hE9); idle(1);
        dsp_peek(1, v); check("R11 dsp write ignored", v[1], 1);
        host_peek(1, v); check("R11 host still sees full", v[0], 0);
        dsp_run = 1; idle(1);
        dsp_peek(1, v); check("R11 move after resume", v[0], 1);
        dsp_rd(2, v); check("R11 word kept", v, 32'hE1);

        // R9 hold
        host_wr(3, 32'h71); host_wr(2, 32'h33); idle(1);
        dsp_wr(0, 32'h1); idle(1);
        host_peek(1, v); check("R9 status cleared", v, 32'h9);
        dsp_peek(1, v); check("R9 dsp status cleared", v, 32'h2);
        host_wr(3, 32'h72); host_wr(2, 32'h44); idle(3);
        host_peek(1, v); check("R9 still held", v, 32'h9);
        host_peek(0, v); check("R9 control kept", v, 32'h3);
        dsp_wr(0, 32'h0); idle(1);

        // R10 initialise downlink only
        host_wr(3, 32'h81); dsp_wr(2, 32'h91); idle(2);
        host_wr(0, 32'h11);
        dsp_peek(1, v); check("R10 dn cleared", v[0], 0);
        host_peek(1, v); check("R10 up kept", v[1:0], 2'b11);
        host_peek(0, v); check("R10 init reads zero", v, 32'h1);

        // R12 unused locations
        host_rd(9, v); check("R12 read zero", v, 0);
        host_wr(9, 32'hFFFF_FFFF); idle(1);
        host_peek(0, v); check("R12 ctrl unchanged", v, 32'h1);
        host_peek(1, v); check("R12 status unchanged", v, 32'h3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule